// File: doc/BRIEF.md
# Shifted-Operand Add/Subtract Unit

This block is a one-cycle integer datapath. The second operand goes through a barrel shifter first. The shifter moves it by any distance from 0 to 31 bit positions in a single pass. The shifted value then meets the first operand in one adder. That adder computes a sum, a normal difference (first minus shifted second) or a reverse difference (shifted second minus first). The result, a carry flag and a zero flag are captured in output registers on the next rising clock edge.

Tying both operand inputs to the same source value turns one operation into a multiplication by a constant:
- add with a left shift of n gives the value times 2^n + 1;
- reverse subtract with a left shift of n gives the value times 2^n - 1;
- a bare left shift gives the value times 2^n.

Top module: `shadd_unit`

## Requirements
- R1: A result, and both of its flags, appear on the outputs at the first rising clock edge after the inputs are applied. The outputs keep their value between edges.
- R2: Shift code 0 is a logical left shift of operand B. It moves B by the amount on `shamt_i`, from 0 to 31 positions, in one pass, and zeros enter at the bottom.
- R3: Shift code 1 is a logical right shift of operand B, and zeros fill the vacated upper bits. Shift code 2 is an arithmetic right shift, and copies of bit 31 of B fill the vacated upper bits.
- R4: A shift amount of 0 passes operand B through unchanged, whatever the shift code.
- R5: Opcode 0 (add) gives A plus the shifted B, modulo 2^32.
- R6: Opcode 1 (subtract) gives A minus the shifted B, modulo 2^32.
- R7: Opcode 2 (reverse subtract) gives the shifted B minus A, modulo 2^32.
- R8: For add, the carry flag is the carry out of bit 31. For either subtract, the carry flag is 1 exactly when the minuend is greater than or equal to the subtrahend as unsigned numbers (no borrow).
- R9: The zero flag is 1 exactly when the registered 32-bit result is zero.
- R10: While `rst_n` is low, the result, carry and zero outputs are all 0. The reset takes effect without waiting for a clock edge.
- R11: Shift code 3 applies no shift. Opcode 3 behaves as add.
- R12: With A equal to B = x, add with a left shift of n gives x*(2^n+1) mod 2^32. Reverse subtract with a left shift of 4 gives x*15 mod 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opa_i | input | 32 | Operand A, not shifted |
| opb_i | input | 32 | Operand B, fed through the shifter |
| shamt_i | input | 5 | Shift distance, 0 to 31 |
| shkind_i | input | 2 | Shift code: 0 left logical, 1 right logical, 2 right arithmetic, 3 none |
| op_i | input | 2 | Opcode: 0 add, 1 subtract, 2 reverse subtract, 3 add |
| result_o | output | 32 | Registered result |
| carry_o | output | 1 | Registered carry / not-borrow flag |
| zero_o | output | 1 | Registered zero flag |

## Verification
The properties assume that every operand, opcode and shift input holds a known value through each rising edge after reset is released. They relate the outputs at one edge to the inputs captured at the edge before. For that reason they are gated until one full clock with reset high has passed. The stimulus changes inputs only on falling edges and drives defined values from time zero. It releases reset on a falling edge, so no input is unknown or changing when a capture edge arrives.

// File: rtl/shadd_pkg.sv
package shadd_pkg;

  typedef enum logic [1:0] {
    SHK_LSL  = 2'd0,
    SHK_LSR  = 2'd1,
    SHK_ASR  = 2'd2,
    SHK_NONE = 2'd3
  } shift_kind_e;

  typedef enum logic [1:0] {
    AOP_ADD     = 2'd0,
    AOP_SUB     = 2'd1,
    AOP_RSB     = 2'd2,
    AOP_ADD_ALT = 2'd3
  } arith_op_e;

endpackage

// File: rtl/shadd_shifter.sv
module shadd_shifter
  import shadd_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = 5
) (
  input  logic [DATA_W-1:0]  din,
  input  logic [SHAMT_W-1:0] amt,
  input  shift_kind_e        kind,
  output logic [DATA_W-1:0]  dout
);

  // Code 3 forces a zero distance (R11)
  logic [SHAMT_W-1:0] eff_amt;
  assign eff_amt = (kind == SHK_NONE) ? '0 : amt;

  logic [DATA_W-1:0] stage [SHAMT_W+1];
  assign stage[0] = din;

  // One mux stage per bit of the shift distance
  for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    logic [DATA_W-1:0] moved;

    always_comb begin
      unique case (kind)
        SHK_LSR: moved = stage[k] >> STEP;
        SHK_ASR: moved = $signed(stage[k]) >>> STEP;
        default: moved = stage[k] << STEP;
      endcase
    end

    assign stage[k+1] = eff_amt[k] ? moved : stage[k];
  end

  assign dout = stage[SHAMT_W];

endmodule

// File: rtl/shadd_arith.sv
module shadd_arith
  import shadd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb_sh,
  input  arith_op_e         op,
  output logic [DATA_W-1:0] sum,
  output logic              cout
);

  logic [DATA_W-1:0] lhs;
  logic [DATA_W-1:0] rhs;
  logic              cin;

  // Swap and invert the inputs so that one adder serves all three ops
  always_comb begin
    unique case (op)
      AOP_SUB: begin
        lhs = opa;
        rhs = ~opb_sh;
        cin = 1'b1;
      end
      AOP_RSB: begin
        lhs = opb_sh;
        rhs = ~opa;
        cin = 1'b1;
      end
      default: begin
        lhs = opa;
        rhs = opb_sh;
        cin = 1'b0;
      end
    endcase
  end

  always_comb begin
    {cout, sum} = {1'b0, lhs} + {1'b0, rhs} + {{DATA_W{1'b0}}, cin};
  end

endmodule

// File: rtl/shadd_unit.sv
module shadd_unit
  import shadd_pkg::*;
#(
  parameter  int DATA_W  = 32,
  localparam int SHAMT_W = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DATA_W-1:0]  opa_i,
  input  logic [DATA_W-1:0]  opb_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  input  logic [1:0]         shkind_i,
  input  logic [1:0]         op_i,
  output logic [DATA_W-1:0]  result_o,
  output logic               carry_o,
  output logic               zero_o
);

  logic [DATA_W-1:0] opb_sh;
  logic [DATA_W-1:0] sum;
  logic              cout;

  shadd_shifter #(
    .DATA_W (DATA_W),
    .SHAMT_W(SHAMT_W)
  ) u_shifter (
    .din (opb_i),
    .amt (shamt_i),
    .kind(shift_kind_e'(shkind_i)),
    .dout(opb_sh)
  );

  shadd_arith #(
    .DATA_W(DATA_W)
  ) u_arith (
    .opa   (opa_i),
    .opb_sh(opb_sh),
    .op    (arith_op_e'(op_i)),
    .sum   (sum),
    .cout  (cout)
  );

  // Next-state
  logic [DATA_W-1:0] result_d;
  logic              carry_d;
  logic              zero_d;

  always_comb begin
    result_d = sum;
    carry_d  = cout;
    zero_d   = (sum == '0);
  end

  // Registers
  logic [DATA_W-1:0] result_q;
  logic              carry_q;
  logic              zero_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      carry_q  <= 1'b0;
      zero_q   <= 1'b0;
    end else begin
      result_q <= result_d;
      carry_q  <= carry_d;
      zero_q   <= zero_d;
    end
  end

  assign result_o = result_q;
  assign carry_o  = carry_q;
  assign zero_o   = zero_q;

endmodule

// File: rtl/shadd_unit_chk.sv
module shadd_unit_chk #(
  parameter int DATA_W  = 32,
  parameter int SHAMT_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [DATA_W-1:0]  opa_i,
  input logic [DATA_W-1:0]  opb_i,
  input logic [SHAMT_W-1:0] shamt_i,
  input logic [1:0]         shkind_i,
  input logic [1:0]         op_i,
  input logic [DATA_W-1:0]  result_o,
  input logic               carry_o,
  input logic               zero_o
);

  // Set once a full clock with reset high has passed
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  a_r9_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (zero_o == (result_o == '0)));

  // Unshifted add also covers R4 pass-through
  a_r5_add_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(shamt_i) == '0 && $past(op_i) == 2'd0)
      |-> (result_o == $past(opa_i) + $past(opb_i)));

  a_r6_sub_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(shamt_i) == '0 && $past(op_i) == 2'd1)
      |-> (result_o == $past(opa_i) - $past(opb_i)));

  a_r7_rsb_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(shamt_i) == '0 && $past(op_i) == 2'd2)
      |-> (result_o == $past(opb_i) - $past(opa_i)));

  a_r8_sub_noborrow: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(shamt_i) == '0 && $past(op_i) == 2'd1)
      |-> (carry_o == ($past(opa_i) >= $past(opb_i))));

  a_r4_r3_lsr_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(shkind_i) == 2'd1 && $past(shamt_i) == 5'd31 && $past(op_i) == 2'd0
      && $past(opa_i) == '0)
      |-> (result_o[DATA_W-1:1] == '0));

endmodule

bind shadd_unit shadd_unit_chk #(
  .DATA_W (DATA_W),
  .SHAMT_W(SHAMT_W)
) u_chk (.*);

// File: tb/shadd_unit_tb.sv
module shadd_unit_tb;

  logic        clk;
  logic        rst_n;
  logic [31:0] opa_i;
  logic [31:0] opb_i;
  logic [4:0]  shamt_i;
  logic [1:0]  shkind_i;
  logic [1:0]  op_i;
  logic [31:0] result_o;
  logic        carry_o;
  logic        zero_o;

  int checks;
  int failures;
  bit done;

  shadd_unit u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .opa_i   (opa_i),
    .opb_i   (opb_i),
    .shamt_i (shamt_i),
    .shkind_i(shkind_i),
    .op_i    (op_i),
    .result_o(result_o),
    .carry_o (carry_o),
    .zero_o  (zero_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Arithmetic reference model
  function automatic logic [31:0] shifted_b(input logic [31:0] b, input int s, input int k);
    longint unsigned ub;
    longint sb;
    ub = {32'd0, b};
    sb = $signed({{32{b[31]}}, b});
    case (k)
      0: return 32'((ub * (64'd1 << s)) % 64'h1_0000_0000);
      1: return 32'(ub / (64'd1 << s));
      2: return 32'(sb >>> s);
      default: return b;
    endcase
  endfunction

  task automatic model(input logic [31:0] a, input logic [31:0] b, input int s, input int k,
                       input int op, output logic [31:0] r, output logic c);
    logic [31:0] bs;
    longint unsigned t;
    bs = shifted_b(b, s, k);
    case (op)
      1: begin r = a - bs; c = (a >= bs); end
      2: begin r = bs - a; c = (bs >= a); end
      default: begin
        t = {32'd0, a} + {32'd0, bs};
        r = t[31:0];
        c = (t >= 64'h1_0000_0000);
      end
    endcase
  endtask

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input int s, input int k, input int op);
    @(negedge clk);
    opa_i    = a;
    opb_i    = b;
    shamt_i  = 5'(s);
    shkind_i = 2'(k);
    op_i     = 2'(op);
  endtask

  task automatic settle();
    @(posedge clk);
    #2;
  endtask

  function automatic string tag_of(input int s, input int k, input int op);
    string st, ot;
    if (s == 0)      st = "R4";
    else if (k == 3) st = "R11";
    else if (k == 0) st = "R2";
    else             st = "R3";
    case (op)
      0: ot = "R5";
      1: ot = "R6";
      2: ot = "R7";
      default: ot = "R11";
    endcase
    return {ot, "/", st};
  endfunction

  task automatic pattern(input int p, output logic [31:0] a, output logic [31:0] b);
    case (p)
      0: begin a = 32'h0000_0000; b = 32'h0000_0000; end
      1: begin a = 32'hFFFF_FFFF; b = 32'h0000_0001; end
      2: begin a = 32'h1234_5678; b = 32'h8000_0000; end
      3: begin a = 32'hA5A5_F00F; b = 32'hA5A5_F00F; end
      4: begin a = 32'h0000_0003; b = 32'hC3D2_E1F0; end
      default: begin a = 32'h9E37_79B9; b = 32'h7F4A_7C15; end
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b, er, prev;
    logic ec;
    checks = 0;
    failures = 0;
    done = 1'b0;
    rst_n = 1'b0;
    opa_i = 32'h1111_2222;
    opb_i = 32'h3333_4444;
    shamt_i = 5'd0;
    shkind_i = 2'd0;
    op_i = 2'd0;

    // R10: reset state
    repeat (3) @(posedge clk);
    #2;
    chk("R10 result", result_o, 32'd0);
    chk("R10 carry", {31'd0, carry_o}, 32'd0);
    chk("R10 zero", {31'd0, zero_o}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // Sweep: all ops, shift codes, distances, operand patterns
    for (int p = 0; p < 6; p++) begin
      for (int op = 0; op < 4; op++) begin
        for (int k = 0; k < 4; k++) begin
          for (int s = 0; s < 32; s++) begin
            pattern(p, a, b);
            drive(a, b, s, k, op);
            settle();
            model(a, b, s, k, op, er, ec);
            chk(tag_of(s, k, op), result_o, er);
            chk("R8 carry", {31'd0, carry_o}, {31'd0, ec});
            chk("R9 zero", {31'd0, zero_o}, {31'd0, (er == 32'd0)});
          end
        end
      end
    end

    // R1: output holds until the next rising edge
    drive(32'h0000_0010, 32'h0000_0001, 0, 0, 0);
    settle();
    prev = result_o;
    drive(32'h0000_0100, 32'h0000_0002, 3, 0, 0);
    #2;
    chk("R1 hold", result_o, prev);
    settle();
    chk("R1 update", result_o, 32'h0000_0110);

    // R12: multiply by constants with both operands equal
    drive(32'h0012_3457, 32'h0012_3457, 4, 0, 2);
    settle();
    chk("R12 x15", result_o, 32'(64'h0012_3457 * 64'd15));
    for (int n = 0; n < 32; n++) begin
      drive(32'hDEAD_BEEF, 32'hDEAD_BEEF, n, 0, 0);
      settle();
      chk("R12 x(2^n+1)", result_o, 32'(64'hDEAD_BEEF * ((64'd1 << n) + 64'd1)));
    end

    // R10: asynchronous reset between edges
    drive(32'h0000_0005, 32'h0000_0007, 0, 0, 0);
    settle();
    #3;
    rst_n = 1'b0;
    #1;
    chk("R10 async result", result_o, 32'd0);
    chk("R10 async carry", {31'd0, carry_o}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule